// File: doc/BRIEF.md
# Operand Hazard Resolver for a Five-Stage Pipeline

This block sits beside the decode stage of an in-order five-stage integer pipeline. Each cycle it takes the two source register numbers of the instruction being decoded. It compares them with the destination numbers held in the execute, memory and writeback pipeline registers, and for each operand it picks the place the operand value should come from: the register file, the execute-stage result, the memory-stage result, or, in one build option, the writeback value. The operand-mux selects are the block's outputs. The muxes themselves and the register file live elsewhere.

A value being loaded from memory by the instruction directly ahead cannot reach the execute stage in time. The block detects that case and raises a stall, which freezes fetch and decode and sends a bubble into execute for one cycle. There is one exception. When the younger instruction is a store that only needs the loaded value as its write data, no stall is raised. Instead the block remembers the case and, two cycles later, when the store has reached the memory stage and the load is in writeback, it raises a select that routes the loaded value straight into the store data path.

The destination and flag inputs come directly from the pipeline registers. Register zero never takes part in a comparison. A stage whose valid bit is low, or whose instruction does not write a register, is ignored.

Top module: `hzfw_unit`

## Requirements
- R1: A source operand matching the destination of a valid, register-writing, non-load instruction in execute selects code 01. A source operand matching such an instruction (load or not) in the memory stage selects code 10. With no match, the select is 00 (register file).
- R2: The first source (rs, select `fwd_a`) and the second source (rt, select `fwd_b`) are resolved independently against all downstream stages.
- R3: When more than one stage matches, the select follows the youngest writer: execute before memory, and memory before writeback.
- R4: A source number of zero always selects 00 and never causes a stall.
- R5: A stage with its valid bit low or its write-enable low never matches. When the decode valid bit is low, both selects are 00 and stall is 0.
- R6: Stall is 1 when a valid load that writes a nonzero register in execute matches rs, or matches rt of an instruction that is not a store. An operand matched by a load in execute selects 00, even if an older stage also matches.
- R7: A valid store whose rt matches a load in execute, while its rs does not, raises no stall. `st_data_byp` is then 1 exactly two clock edges later, and otherwise 0.
- R8: With parameter WB_BYPASS = 0, a writeback match is never forwarded (the select stays 00). With WB_BYPASS = 1, a writeback-only match selects code 11.
- R9: During reset and on the first two cycles after it, `st_data_byp` is 0.
- R10: A stalled store (its rs matching the load in execute) does not raise `st_data_byp` two cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_rs | input | REG_W | First source register number |
| id_rt | input | REG_W | Second source register number (store data for stores) |
| id_is_store | input | 1 | Decode instruction is a store |
| ex_valid | input | 1 | Execute stage valid |
| ex_rd | input | REG_W | Execute stage destination |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_valid | input | 1 | Memory stage valid |
| mem_rd | input | REG_W | Memory stage destination |
| mem_wen | input | 1 | Memory instruction writes a register |
| wb_valid | input | 1 | Writeback stage valid |
| wb_rd | input | REG_W | Writeback stage destination |
| wb_wen | input | 1 | Writeback instruction writes a register |
| fwd_a | output | 2 | Select for first operand: 00 file, 01 execute, 10 memory, 11 writeback |
| fwd_b | output | 2 | Select for second operand, same encoding |
| stall | output | 1 | Hold fetch and decode, bubble into execute |
| st_data_byp | output | 1 | Route load result into the store data of the memory stage |

## Verification
The selects are tried with register numbers drawn from a set of only four values, so that single, double and triple matches across the stages occur often. These cases separate correct youngest-writer priority from any other order, and they show whether the valid and write-enable gating is applied per stage. Register zero is mixed in at the same rate, which exposes any comparison that leaks through it. Load-in-execute cases are mixed with stores whose address, data operand or both collide. These cases separate stall from store-data bypass and check the two-edge timing of the bypass flag. Two builds run side by side on the same stimulus, one with writeback forwarding and one without, so that the writeback-only matches tell the two variants apart.

// File: rtl/hzfw_pkg.sv
package hzfw_pkg;

   typedef enum logic [1:0] {
      SRC_RF  = 2'b00,
      SRC_EX  = 2'b01,
      SRC_MEM = 2'b10,
      SRC_WB  = 2'b11
   } byp_sel_e;

   // stage slot positions inside the per-stage vectors
   localparam int STG_EX  = 0;
   localparam int STG_MEM = 1;
   localparam int STG_WB  = 2;
   localparam int NUM_STG = 3;

endpackage

// File: rtl/hzfw_src_resolve.sv
module hzfw_src_resolve
   import hzfw_pkg::*;
#(
   parameter int REG_W     = 5,
   parameter int WB_BYPASS = 0
) (
   input  logic               dec_vld,
   input  logic [REG_W-1:0]   src,
   input  logic [REG_W-1:0]   stg_rd [NUM_STG],
   input  logic [NUM_STG-1:0] stg_vld,
   input  logic [NUM_STG-1:0] stg_wen,
   input  logic               ex_is_load,
   output byp_sel_e           sel,
   output logic               ex_load_hit
);

   logic               src_nz;
   logic [NUM_STG-1:0] hit;
   logic               wb_take;

   assign src_nz = (src != '0);

   generate
      for (genvar s = 0; s < NUM_STG; s++) begin : g_cmp
         assign hit[s] = stg_vld[s] & stg_wen[s] & src_nz & (stg_rd[s] == src);
      end
   endgenerate

   generate
      if (WB_BYPASS != 0) begin : g_wb_on
         assign wb_take = hit[STG_WB];
      end else begin : g_wb_off
         logic wb_unused;
         assign wb_unused = hit[STG_WB];
         assign wb_take   = 1'b0 & wb_unused;
      end
   endgenerate

   always_comb begin
      sel = SRC_RF;
      if (dec_vld) begin
         if (hit[STG_EX]) begin
            sel = ex_is_load ? SRC_RF : SRC_EX;
         end else if (hit[STG_MEM]) begin
            sel = SRC_MEM;
         end else if (wb_take) begin
            sel = SRC_WB;
         end
      end
   end

   assign ex_load_hit = dec_vld & hit[STG_EX] & ex_is_load;

endmodule

// File: rtl/hzfw_loaduse.sv
module hzfw_loaduse (
   input  logic dec_vld,
   input  logic dec_store,
   input  logic a_ld_hit,
   input  logic b_ld_hit,
   output logic stall,
   output logic st_byp_req
);

   logic b_needs_stall;

   // store data is consumed late, so only a non-store rt waits
   assign b_needs_stall = b_ld_hit & ~dec_store;
   assign stall         = dec_vld & (a_ld_hit | b_needs_stall);
   assign st_byp_req    = dec_vld & dec_store & b_ld_hit & ~a_ld_hit;

endmodule

// File: rtl/hzfw_store_track.sv
module hzfw_store_track #(
   parameter int DEPTH = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic byp
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("hzfw_store_track: DEPTH must be at least 2");
      end
   endgenerate

   logic [DEPTH-1:0] line_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q <= '0;
      end else begin
         line_q <= {line_q[DEPTH-2:0], req};
      end
   end

   assign byp = line_q[DEPTH-1];

endmodule

// File: rtl/hzfw_unit.sv
module hzfw_unit
   import hzfw_pkg::*;
#(
   parameter int REG_W     = 5,
   parameter int WB_BYPASS = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             id_valid,
   input  logic [REG_W-1:0] id_rs,
   input  logic [REG_W-1:0] id_rt,
   input  logic             id_is_store,
   input  logic             ex_valid,
   input  logic [REG_W-1:0] ex_rd,
   input  logic             ex_wen,
   input  logic             ex_load,
   input  logic             mem_valid,
   input  logic [REG_W-1:0] mem_rd,
   input  logic             mem_wen,
   input  logic             wb_valid,
   input  logic [REG_W-1:0] wb_rd,
   input  logic             wb_wen,
   output logic [1:0]       fwd_a,
   output logic [1:0]       fwd_b,
   output logic             stall,
   output logic             st_data_byp
);

   localparam int DEC_TO_MEM = 2;   // decode -> execute -> memory
   localparam int NUM_SRC    = 2;

   generate
      if (REG_W < 1 || REG_W > 8) begin : g_bad_regw
         $error("hzfw_unit: REG_W out of range");
      end
      if (WB_BYPASS != 0 && WB_BYPASS != 1) begin : g_bad_wb
         $error("hzfw_unit: WB_BYPASS must be 0 or 1");
      end
   endgenerate

   logic [REG_W-1:0]   rd_vec [NUM_STG];
   logic [NUM_STG-1:0] vld_vec;
   logic [NUM_STG-1:0] wen_vec;
   logic [REG_W-1:0]   src_vec [NUM_SRC];
   byp_sel_e           sel_vec [NUM_SRC];
   logic [NUM_SRC-1:0] ld_hit;
   logic               req;

   assign rd_vec[STG_EX]  = ex_rd;
   assign rd_vec[STG_MEM] = mem_rd;
   assign rd_vec[STG_WB]  = wb_rd;
   assign vld_vec = {wb_valid, mem_valid, ex_valid};
   assign wen_vec = {wb_wen, mem_wen, ex_wen};
   assign src_vec[0] = id_rs;
   assign src_vec[1] = id_rt;

   generate
      for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
         hzfw_src_resolve #(
            .REG_W     (REG_W),
            .WB_BYPASS (WB_BYPASS)
         ) u_res (
            .dec_vld     (id_valid),
            .src         (src_vec[k]),
            .stg_rd      (rd_vec),
            .stg_vld     (vld_vec),
            .stg_wen     (wen_vec),
            .ex_is_load  (ex_load),
            .sel         (sel_vec[k]),
            .ex_load_hit (ld_hit[k])
         );
      end
   endgenerate

   hzfw_loaduse u_lu (
      .dec_vld    (id_valid),
      .dec_store  (id_is_store),
      .a_ld_hit   (ld_hit[0]),
      .b_ld_hit   (ld_hit[1]),
      .stall      (stall),
      .st_byp_req (req)
   );

   hzfw_store_track #(
      .DEPTH (DEC_TO_MEM)
   ) u_trk (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req),
      .byp   (st_data_byp)
   );

   assign fwd_a = sel_vec[0];
   assign fwd_b = sel_vec[1];

   AST_STALL_ONLY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (ex_valid && ex_wen && ex_load && ex_rd != '0)); // R6
   AST_ZERO_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
      (id_rs == '0) |-> (fwd_a == 2'b00)); // R4
   AST_EX_SEL_NOT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_b == 2'b01) |-> (ex_valid && ex_wen && !ex_load && ex_rd == id_rt)); // R1
   AST_WB_SEL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_a == 2'b11) |-> (WB_BYPASS == 1 && wb_valid && wb_wen)); // R8
   AST_BYP_FROM_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      st_data_byp |-> $past(id_valid && id_is_store && !stall, 2)); // R7
   AST_NO_BYP_AFTER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> ##2 !st_data_byp); // R10
   AST_IDLE_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
      !id_valid |-> (!stall && fwd_a == 2'b00 && fwd_b == 2'b00)); // R5

endmodule

// File: tb/tb_hzfw_unit.sv
module tb_hzfw_unit;

   localparam int RW = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          id_valid = 0, id_is_store = 0;
   logic [RW-1:0] id_rs = '0, id_rt = '0;
   logic          ex_valid = 0, ex_wen = 0, ex_load = 0;
   logic [RW-1:0] ex_rd = '0;
   logic          mem_valid = 0, mem_wen = 0;
   logic [RW-1:0] mem_rd = '0;
   logic          wb_valid = 0, wb_wen = 0;
   logic [RW-1:0] wb_rd = '0;

   logic [1:0] fa0, fb0, fa1, fb1;
   logic       st0, st1, by0, by1;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   hzfw_unit #(.REG_W(RW), .WB_BYPASS(0)) dut (
      .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_rs(id_rs), .id_rt(id_rt),
      .id_is_store(id_is_store), .ex_valid(ex_valid), .ex_rd(ex_rd), .ex_wen(ex_wen),
      .ex_load(ex_load), .mem_valid(mem_valid), .mem_rd(mem_rd), .mem_wen(mem_wen),
      .wb_valid(wb_valid), .wb_rd(wb_rd), .wb_wen(wb_wen),
      .fwd_a(fa0), .fwd_b(fb0), .stall(st0), .st_data_byp(by0));

   hzfw_unit #(.REG_W(RW), .WB_BYPASS(1)) dut_wb (
      .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_rs(id_rs), .id_rt(id_rt),
      .id_is_store(id_is_store), .ex_valid(ex_valid), .ex_rd(ex_rd), .ex_wen(ex_wen),
      .ex_load(ex_load), .mem_valid(mem_valid), .mem_rd(mem_rd), .mem_wen(mem_wen),
      .wb_valid(wb_valid), .wb_rd(wb_rd), .wb_wen(wb_wen),
      .fwd_a(fa1), .fwd_b(fb1), .stall(st1), .st_data_byp(by1));

   // ---------------- reference model ----------------
   function automatic int m_sel(input logic [RW-1:0] src, input bit wbb);
      if (!id_valid || src == 0) return 0;
      if (ex_valid && ex_wen && ex_rd == src) return ex_load ? 0 : 1;
      if (mem_valid && mem_wen && mem_rd == src) return 2;
      if (wbb && wb_valid && wb_wen && wb_rd == src) return 3;
      return 0;
   endfunction

   function automatic bit m_ldhit(input logic [RW-1:0] src);
      return id_valid && src != 0 && ex_valid && ex_wen && ex_load && ex_rd == src;
   endfunction

   function automatic bit m_stall();
      return m_ldhit(id_rs) || (m_ldhit(id_rt) && !id_is_store);
   endfunction

   function automatic bit m_req();
      return id_is_store && m_ldhit(id_rt) && !m_ldhit(id_rs);
   endfunction

   bit hist[$];
   always @(posedge clk) begin
      if (!rst_n) hist.delete();
      else hist.push_back(m_req());
   end

   function automatic bit m_byp();
      if (hist.size() < 2) return 0;
      return hist[hist.size()-2];
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk("R1 R2 R3 R4 R5 R6 fwd_a", fa0, m_sel(id_rs, 0));
      chk("R1 R2 R3 R4 R5 R6 fwd_b", fb0, m_sel(id_rt, 0));
      chk("R8 fwd_a wb build", fa1, m_sel(id_rs, 1));
      chk("R8 fwd_b wb build", fb1, m_sel(id_rt, 1));
      chk("R6 R4 R5 stall", st0, m_stall());
      chk("R6 stall wb build", st1, m_stall());
      chk("R7 R10 R9 st_data_byp", by0, m_byp());
      chk("R7 R10 st_data_byp wb build", by1, m_byp());
   endtask

   task automatic clear_inputs();
      id_valid = 0; id_is_store = 0; id_rs = 0; id_rt = 0;
      ex_valid = 0; ex_wen = 0; ex_load = 0; ex_rd = 0;
      mem_valid = 0; mem_wen = 0; mem_rd = 0;
      wb_valid = 0; wb_wen = 0; wb_rd = 0;
   endtask

   task automatic step();
      #1;
      compare_all();
      @(negedge clk);
   endtask

   function automatic logic [RW-1:0] rreg();
      return RW'($urandom_range(0, 3));
   endfunction

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R9: reset state
      repeat (3) @(negedge clk);
      chk("R9 byp in reset", by0, 0);
      chk("R9 byp in reset wb build", by1, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R7: load r3 in execute, store data uses r3, address r1
      clear_inputs();
      ex_valid = 1; ex_wen = 1; ex_load = 1; ex_rd = 3;
      id_valid = 1; id_is_store = 1; id_rs = 1; id_rt = 3;
      step();
      clear_inputs(); step();
      chk("R7 byp two edges after store", by0, 1);
      step();
      chk("R7 byp lasts one cycle", by0, 0);

      // R10: stalled store, address collides with load
      ex_valid = 1; ex_wen = 1; ex_load = 1; ex_rd = 2;
      id_valid = 1; id_is_store = 1; id_rs = 2; id_rt = 2;
      #1; chk("R10 store stalls", st0, 1);
      @(negedge clk);
      clear_inputs(); step(); step();
      chk("R10 no byp after stall", by0, 0);

      // R6: load-use on rs
      ex_valid = 1; ex_wen = 1; ex_load = 1; ex_rd = 4;
      mem_valid = 1; mem_wen = 1; mem_rd = 4;
      id_valid = 1; id_rs = 4; id_rt = 1;
      #1;
      chk("R6 load-use stall", st0, 1);
      chk("R6 loaded operand selects file", fa0, 0);
      @(negedge clk); clear_inputs();

      // R3: execute beats memory
      ex_valid = 1; ex_wen = 1; ex_rd = 2;
      mem_valid = 1; mem_wen = 1; mem_rd = 2;
      wb_valid = 1; wb_wen = 1; wb_rd = 2;
      id_valid = 1; id_rs = 2; id_rt = 2;
      #1;
      chk("R3 execute wins", fa0, 1);
      chk("R3 execute wins rt", fb1, 1);
      @(negedge clk); clear_inputs();

      // R4: register zero
      ex_valid = 1; ex_wen = 1; ex_rd = 0;
      id_valid = 1; id_rs = 0; id_rt = 0;
      #1;
      chk("R4 zero no forward", fa0, 0);
      @(negedge clk); clear_inputs();

      // R8: writeback-only match
      wb_valid = 1; wb_wen = 1; wb_rd = 5;
      id_valid = 1; id_rs = 5; id_rt = 5;
      #1;
      chk("R8 no wb forward", fa0, 0);
      chk("R8 wb forward", fa1, 3);
      @(negedge clk); clear_inputs();

      // R5: invalid writer ignored
      ex_valid = 0; ex_wen = 1; ex_rd = 6;
      mem_valid = 1; mem_wen = 0; mem_rd = 6;
      id_valid = 1; id_rs = 6; id_rt = 6;
      #1;
      chk("R5 gated stages", fa0, 0);
      @(negedge clk); clear_inputs();

      // mixed random traffic, model compared every cycle (R1 R2 R3 R5 R6 R7)
      for (int i = 0; i < 3000; i++) begin
         id_valid    = ($urandom_range(0, 7) != 0);
         id_is_store = ($urandom_range(0, 2) == 0);
         id_rs = rreg(); id_rt = rreg();
         ex_valid  = ($urandom_range(0, 3) != 0);
         ex_wen    = ($urandom_range(0, 3) != 0);
         ex_load   = ($urandom_range(0, 2) == 0);
         ex_rd     = rreg();
         mem_valid = ($urandom_range(0, 3) != 0);
         mem_wen   = ($urandom_range(0, 3) != 0);
         mem_rd    = rreg();
         wb_valid  = ($urandom_range(0, 3) != 0);
         wb_wen    = ($urandom_range(0, 3) != 0);
         wb_rd     = rreg();
         step();
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule